// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a CPU core and its peripherals. It collects the maskable interrupt flags from a USB function, an external interrupt pin together with a port-pin interrupt, three timer events and a keyboard, and applies each source's own enable or mask. It then blocks every hardware level while a global mask bit is set and picks the most urgent pending level. The CPU receives a request line, a 16-bit vector fetch address, a level index and a flag. The flag says whether the saved return address is the current PC (software interrupt) or PC minus one (hardware interrupt). A software-interrupt request bypasses the global mask and outranks all hardware levels. A read-only status vector mirrors the enabled, pending state of each hardware level, so a debugger can see it.

The core is a two-state machine. `ST_IDLE` waits for an eligible level. The transition `GRANT` (`ST_IDLE` to `ST_PRESENT`) captures the winning level. In `ST_PRESENT` the presented level is held. The `PREEMPT` self-transition replaces it only with a strictly more urgent level. The `RETIRE` transition (`ST_PRESENT` to `ST_IDLE`) follows a one-cycle acknowledge. Retiring a hardware level sets the global mask. The CPU clears the mask again on return from interrupt.

Top module: `intvec_ctrl`

## Requirements
- R1: A latched software-interrupt request is presented whatever the global mask says, and it wins over every hardware level (index 0).
- R2: While `glob_mask` is 1, no hardware level is presented.
- R3: Level indices, with 0 the most urgent: software 0, USB group 1, pin group 2, timer channel 0 is 3, timer channel 1 is 4, timer overflow 5, keyboard 6. `tmr_flag`/`tmr_en` bit 0 is channel 0, bit 1 is channel 1 and bit 2 is overflow.
- R4: While `int_req` is 1, `vec_addr` equals 16'hFFFC minus twice `src_idx`, so the outputs run from 16'hFFFC down to 16'hFFF0. While `int_req` is 0, `vec_addr` and `src_idx` are 0.
- R5: The USB level is pending when any `usb_flag[i]` has its `usb_en[i]` set, or when `usb_resume` is 1. `usb_resume` has no enable.
- R6: The pin level is pending when `irq_flag` or `port_flag` is 1 and the shared `irq_mask` is 0.
- R7: `int_status` has bit 0 for the pin level, bit 1 for USB, and bits 2 to 5 for timer channel 0, timer channel 1, timer overflow and keyboard. Each bit shows its level's enabled, pending state at once. The bits do not depend on the global mask or on acknowledge.
- R8: `ret_pc_cur` is 1 exactly while the software interrupt is presented.
- R9: `int_req` rises on the clock edge after a level becomes eligible. While it is high and `int_ack` is 0, it stays high, and `src_idx` can only move to a more urgent level. It falls on the edge that samples `int_ack`. An acknowledge while idle has no effect.
- R10: A more urgent eligible level that arrives before acknowledge replaces the presented one. A less urgent one does not.
- R11: `glob_mask` is 1 after reset. It becomes 1 on the acknowledge of a hardware level or on `mask_set`. It becomes 0 on `mask_clear`, and setting wins over clearing. Acknowledging the software interrupt leaves it unchanged.
- R12: A one-cycle `swi_req` pulse is held pending until the software interrupt is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_flag | input | 7 | USB event flags (bus reset, endpoint events, end of packet) |
| usb_en | input | 7 | Per-flag USB enables |
| usb_resume | input | 1 | USB resume flag, no enable |
| irq_flag | input | 1 | External interrupt pin flag |
| port_flag | input | 1 | Port-pin interrupt flag |
| irq_mask | input | 1 | Shared mask for the pin level, 1 blocks |
| tmr_flag | input | 3 | Timer channel 0, channel 1 and overflow flags |
| tmr_en | input | 3 | Timer enables |
| kbd_flag | input | 1 | Keyboard flag |
| kbd_mask | input | 1 | Keyboard mask, 1 blocks |
| swi_req | input | 1 | Software-interrupt request pulse |
| int_ack | input | 1 | One-cycle acknowledge from the CPU |
| mask_set | input | 1 | Set the global mask |
| mask_clear | input | 1 | Clear the global mask (return from interrupt) |
| int_req | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector fetch address (high byte; low byte at +1) |
| src_idx | output | 3 | Presented level index |
| ret_pc_cur | output | 1 | 1: save the current PC, 0: save PC minus one |
| glob_mask | output | 1 | Global interrupt mask |
| int_status | output | 6 | Read-only per-level pending flags |

## Verification
Each source is first raised alone, with its enable both clear and set. This separates the enable gating of the USB, pin, timer and keyboard groups from the arbitration, and shows that the resume flag requests without an enable. The same sources are then raised while the global mask is set, so the bench can tell mask blocking apart from enable blocking and confirm that the software request gets through anyway. Overlapping requests are applied in rising and falling urgency during a presentation, which separates correct preemption from a latch-once or a latest-wins arbiter. Acknowledges are given in both states, and for software and hardware levels, to pin down the mask side effects.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
    localparam int USB_N_DEF = 7;
    localparam int TMR_N_DEF = 3;
    localparam logic [15:0] VEC_TOP = 16'hFFFC;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ivc_state_e;
endpackage

// File: rtl/intvec_gather.sv
module intvec_gather #(
    parameter int USB_N   = 7,
    parameter int TMR_N   = 3,
    parameter int NUM_LVL = TMR_N + 4
) (
    input  logic [USB_N-1:0]   usb_flag,
    input  logic [USB_N-1:0]   usb_en,
    input  logic               usb_resume,
    input  logic               irq_flag,
    input  logic               port_flag,
    input  logic               irq_mask,
    input  logic [TMR_N-1:0]   tmr_flag,
    input  logic [TMR_N-1:0]   tmr_en,
    input  logic               kbd_flag,
    input  logic               kbd_mask,
    output logic [NUM_LVL-1:0] lvl_pend
);
    localparam int LVL_USB = 1;
    localparam int LVL_PIN = 2;
    localparam int LVL_TMR = 3;
    localparam int LVL_KBD = LVL_TMR + TMR_N;

    // level 0 (software) is not a peripheral source
    assign lvl_pend[0]       = 1'b0;
    assign lvl_pend[LVL_USB] = (|(usb_flag & usb_en)) | usb_resume;
    assign lvl_pend[LVL_PIN] = (irq_flag | port_flag) & ~irq_mask;
    assign lvl_pend[LVL_KBD] = kbd_flag & ~kbd_mask;

    for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
        assign lvl_pend[LVL_TMR + t] = tmr_flag[t] & tmr_en[t];
    end
endmodule

// File: rtl/intvec_arbiter.sv
module intvec_arbiter #(
    parameter int NUM_LVL = 7,
    parameter int IDX_W   = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] elig,
    output logic               win_any,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_LVL-1:0] grant;

    // one-hot grant: a level wins when no lower index is eligible
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_grant
        if (g == 0) begin : g_top
            assign grant[g] = elig[g];
        end else begin : g_rest
            assign grant[g] = elig[g] & ~(|elig[g-1:0]);
        end
    end

    always_comb begin
        win_any = |grant;
        win_idx = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (grant[i]) win_idx = IDX_W'(i);
        end
    end

    // R3
    always_comb begin
        single_grant_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/intvec_fsm.sv
module intvec_fsm
    import intvec_pkg::*;
#(
    parameter int NUM_LVL = 7,
    parameter int IDX_W   = $clog2(NUM_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             ack,
    input  logic             swi_req,
    output logic             req,
    output logic [IDX_W-1:0] cur_idx,
    output logic             swi_pend,
    output logic             hw_ack
);
    ivc_state_e       state, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             swi_q, swi_n;
    logic             swi_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
            swi_q <= 1'b0;
        end else begin
            state <= state_n;
            idx_q <= idx_n;
            swi_q <= swi_n;
        end
    end

    // transitions: GRANT, PREEMPT, RETIRE
    always_comb begin
        state_n = state;
        idx_n   = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (win_any) begin
                    state_n = ST_PRESENT;
                    idx_n   = win_idx;
                end
            end
            ST_PRESENT: begin
                if (ack) begin
                    state_n = ST_IDLE;
                end else if (win_any && (win_idx < idx_q)) begin
                    idx_n = win_idx;
                end
            end
        endcase
    end

    assign swi_done = (state == ST_PRESENT) && ack && (idx_q == '0);
    assign swi_n    = swi_req | (swi_q & ~swi_done);

    // outputs
    always_comb begin
        req      = 1'b0;
        cur_idx  = '0;
        hw_ack   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRESENT: begin
                req     = 1'b1;
                cur_idx = idx_q;
                hw_ack  = ack && (idx_q != '0);
            end
        endcase
    end
    assign swi_pend = swi_q;

    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRESENT && !ack) |=> (state == ST_PRESENT && idx_q <= $past(idx_q)));

    // R12
    swi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_q && !swi_done) |=> swi_q);
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
    import intvec_pkg::*;
#(
    parameter int USB_N = USB_N_DEF,
    parameter int TMR_N = TMR_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [USB_N-1:0] usb_flag,
    input  logic [USB_N-1:0] usb_en,
    input  logic             usb_resume,
    input  logic             irq_flag,
    input  logic             port_flag,
    input  logic             irq_mask,
    input  logic [TMR_N-1:0] tmr_flag,
    input  logic [TMR_N-1:0] tmr_en,
    input  logic             kbd_flag,
    input  logic             kbd_mask,
    input  logic             swi_req,
    input  logic             int_ack,
    input  logic             mask_set,
    input  logic             mask_clear,
    output logic             int_req,
    output logic [15:0]      vec_addr,
    output logic [$clog2(TMR_N+4)-1:0] src_idx,
    output logic             ret_pc_cur,
    output logic             glob_mask,
    output logic [TMR_N+2:0] int_status
);
    localparam int NUM_LVL = TMR_N + 4;
    localparam int IDX_W   = $clog2(NUM_LVL);
    localparam int STAT_W  = NUM_LVL - 1;

    logic [NUM_LVL-1:0] lvl_pend;
    logic [NUM_LVL-1:0] elig;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic               swi_pend;
    logic               hw_ack;
    logic               gmask_q;

    intvec_gather #(.USB_N(USB_N), .TMR_N(TMR_N), .NUM_LVL(NUM_LVL)) u_gather (
        .usb_flag  (usb_flag),
        .usb_en    (usb_en),
        .usb_resume(usb_resume),
        .irq_flag  (irq_flag),
        .port_flag (port_flag),
        .irq_mask  (irq_mask),
        .tmr_flag  (tmr_flag),
        .tmr_en    (tmr_en),
        .kbd_flag  (kbd_flag),
        .kbd_mask  (kbd_mask),
        .lvl_pend  (lvl_pend)
    );

    // software level bypasses the global mask
    assign elig = {lvl_pend[NUM_LVL-1:1] & {(NUM_LVL-1){~gmask_q}}, swi_pend};

    intvec_arbiter #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_arb (
        .elig   (elig),
        .win_any(win_any),
        .win_idx(win_idx)
    );

    intvec_fsm #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_any (win_any),
        .win_idx (win_idx),
        .ack     (int_ack),
        .swi_req (swi_req),
        .req     (int_req),
        .cur_idx (src_idx),
        .swi_pend(swi_pend),
        .hw_ack  (hw_ack)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gmask_q <= 1'b1;
        else if (hw_ack || mask_set) gmask_q <= 1'b1;
        else if (mask_clear)        gmask_q <= 1'b0;
    end
    assign glob_mask = gmask_q;

    assign vec_addr   = int_req ? (VEC_TOP - (16'(src_idx) << 1)) : 16'h0000;
    assign ret_pc_cur = int_req && (src_idx == '0);

    // status order: pin level, USB level, then timers and keyboard
    assign int_status[0] = lvl_pend[2];
    assign int_status[1] = lvl_pend[1];
    for (genvar s = 2; s < STAT_W; s++) begin : g_stat
        assign int_status[s] = lvl_pend[s+1];
    end

    // R11
    hw_ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && src_idx != '0) |=> glob_mask);

    // R2
    masked_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_req) && src_idx != '0) |-> !$past(glob_mask));
endmodule

// File: tb/intvec_ctrl_test.sv
module intvec_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] usb_flag = '0, usb_en = '0;
    logic       usb_resume = 0, irq_flag = 0, port_flag = 0, irq_mask = 0;
    logic [2:0] tmr_flag = '0, tmr_en = '0;
    logic       kbd_flag = 0, kbd_mask = 0, swi_req = 0, int_ack = 0;
    logic       mask_set = 0, mask_clear = 0;
    logic       int_req, ret_pc_cur, glob_mask;
    logic [15:0] vec_addr;
    logic [2:0] src_idx;
    logic [5:0] int_status;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    intvec_ctrl uut (.*);

    // behavioural reference
    bit m_present = 0, m_gmask = 1, m_swi = 0;
    int m_idx = 0;

    function automatic bit [5:0] exp_status();
        bit [5:0] s;
        s[0] = (irq_flag || port_flag) && !irq_mask;
        s[1] = ((usb_flag & usb_en) != 0) || usb_resume;
        for (int k = 0; k < 3; k++) s[2+k] = tmr_flag[k] && tmr_en[k];
        s[5] = kbd_flag && !kbd_mask;
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_present = 0; m_gmask = 1; m_swi = 0; m_idx = 0;
        end else begin
            bit [5:0] st;
            int best;
            bit hwack, swidone;
            st = exp_status();
            best = -1;
            if (m_swi) best = 0;
            else if (!m_gmask) begin
                if (st[1]) best = 1;
                else if (st[0]) best = 2;
                else begin
                    for (int k = 5; k >= 2; k--) if (st[k]) best = k + 1;
                end
            end
            hwack   = m_present && int_ack && m_idx != 0;
            swidone = m_present && int_ack && m_idx == 0;
            if (m_present) begin
                if (int_ack) m_present = 0;
                else if (best >= 0 && best < m_idx) m_idx = best;
            end else if (best >= 0) begin
                m_present = 1; m_idx = best;
            end
            if (hwack || mask_set) m_gmask = 1;
            else if (mask_clear) m_gmask = 0;
            if (swi_req) m_swi = 1;
            else if (swidone) m_swi = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 int_req", int_req, m_present);
            chk("R3 src_idx", src_idx, m_present ? m_idx : 0);
            chk("R4 vec_addr", vec_addr, m_present ? 16'hFFFC - 2*m_idx : 0);
            chk("R8 ret_pc_cur", ret_pc_cur, m_present && m_idx == 0);
            chk("R7 int_status", int_status, exp_status());
            chk("R11 glob_mask", glob_mask, m_gmask);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic pulse_ack();
        int_ack = 1; step(1); int_ack = 0;
    endtask

    task automatic pulse_clear();
        mask_clear = 1; step(1); mask_clear = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        chk("R9 reset req", int_req, 0);
        chk("R11 reset mask", glob_mask, 1);
        chk("R7 reset status", int_status, 0);

        // masked hardware level stays off
        tmr_flag = 3'b001; tmr_en = 3'b001;
        step(3);
        chk("R2 masked", int_req, 0);
        chk("R7 status ch0", int_status, 6'b000100);

        // software interrupt through the mask
        swi_req = 1; step(1); swi_req = 0; step(1);
        chk("R1 swi req", int_req, 1);
        chk("R1 swi idx", src_idx, 0);
        chk("R4 swi vec", vec_addr, 16'hFFFC);
        chk("R8 swi ret", ret_pc_cur, 1);
        step(3);
        chk("R12 swi held", int_req, 1);
        pulse_ack();
        chk("R9 retire", int_req, 0);
        chk("R11 swi ack keeps mask", glob_mask, 1);
        step(2);
        chk("R12 swi cleared", int_req, 0);

        // hardware level after mask clear, then preemption
        pulse_clear();
        step(2);
        chk("R3 ch0 idx", src_idx, 3);
        chk("R4 ch0 vec", vec_addr, 16'hFFF6);
        chk("R8 hw ret", ret_pc_cur, 0);
        usb_resume = 1; step(2);
        chk("R5 resume no enable", src_idx, 1);
        chk("R10 preempt", vec_addr, 16'hFFFA);
        kbd_flag = 1; step(2);
        chk("R10 no lower preempt", src_idx, 1);
        pulse_ack();
        chk("R11 hw ack sets mask", glob_mask, 1);
        step(2);
        chk("R2 all masked", int_req, 0);
        chk("R7 status kept", int_status, 6'b100110);

        // USB enable gating
        usb_resume = 0; tmr_flag = 0; kbd_flag = 0;
        usb_flag = 7'b0001000; usb_en = 7'b0;
        pulse_clear();
        step(3);
        chk("R5 disabled", int_req, 0);
        chk("R7 status none", int_status, 0);
        usb_en = 7'b0001000; step(2);
        chk("R5 enabled", src_idx, 1);
        chk("R7 status usb", int_status, 6'b000010);
        pulse_ack();
        usb_flag = 0; usb_en = 0;

        // pin group with shared mask
        port_flag = 1; irq_mask = 1;
        pulse_clear();
        step(3);
        chk("R6 masked pin", int_req, 0);
        irq_mask = 0; step(2);
        chk("R6 pin idx", src_idx, 2);
        chk("R6 pin vec", vec_addr, 16'hFFF8);
        chk("R7 status pin", int_status, 6'b000001);
        pulse_ack();
        port_flag = 0; irq_flag = 1; step(1);
        pulse_clear(); step(2);
        chk("R6 irq pin", src_idx, 2);
        pulse_ack();
        irq_flag = 0;

        // software wins over every hardware level
        tmr_flag = 3'b111; tmr_en = 3'b111; kbd_flag = 1; usb_resume = 1;
        pulse_clear();
        swi_req = 1; step(1); swi_req = 0; step(1);
        chk("R1 swi wins", src_idx, 0);
        pulse_ack();
        step(2);
        chk("R3 usb next", src_idx, 1);
        pulse_ack();

        // timer order
        usb_resume = 0; kbd_flag = 0; tmr_flag = 3'b110; tmr_en = 3'b110;
        pulse_clear(); step(2);
        chk("R3 ch1 idx", src_idx, 4);
        chk("R4 ch1 vec", vec_addr, 16'hFFF4);
        pulse_ack();
        tmr_flag = 0; tmr_en = 0;

        // ack while idle, mask set/clear precedence
        pulse_clear(); step(1);
        pulse_ack(); step(1);
        chk("R9 idle ack ignored", glob_mask, 0);
        mask_set = 1; mask_clear = 1; step(1); mask_set = 0; mask_clear = 0;
        chk("R11 set wins", glob_mask, 1);
        step(2);
        finish_run();
    end
endmodule